// File: doc/BRIEF.md
# Four-Channel Register-Mapped PWM Controller

This block generates four independent pulse-width-modulated outputs from one input clock. Software sets each channel through a small synchronous register bus: a byte address, a write strobe with 32-bit write data, and 32-bit read data that follows the address combinationally. Each channel has three settings: an enable bit with a 14-bit clock prescaler, a 16-bit high-time count and a 16-bit period count. One chip-wide enable bit gates all four channels.

A running channel divides the clock by its prescaler plus one to make ticks. It counts ticks through the period and holds its output high for the first high-time ticks of each period. New settings are held in shadow copies. A running channel takes them only when a period ends, so a write in mid-period never cuts a pulse short or stretches it. When a channel is stopped, its counters are cleared. When it starts again, it begins at the start of a period.

Top module: `pwm_bank`

## Requirements
- R1: Byte addresses are word aligned. Channel n (0 to 3) owns the window that starts at n×0x10. Within the window, +0x0 is the control word, +0x4 the high-time count and +0x8 the period count. Each channel's registers are separate from the others.
- R2: The control word reads back the enable in bit 0 and the prescale value in bits [15:2]. All other bits read as zero. The high-time and period registers keep bits [15:0] of the write data and read back those 16 bits with zero above them.
- R3: The global enable is bit 0 of the word at 0x3C and reads back. While it is zero, every output is low one cycle later, whatever the channel enables are.
- R4: An output can be high only while both the global enable and its channel enable are set. The output follows a register write one cycle after the write edge. A stopped channel restarts at the beginning of a period.
- R5: With prescale P and period count PV, one output period lasts (P+1)×max(PV,1) clock cycles.
- R6: With high-time count DC, the output is high for the first (P+1)×DC cycles of each period. If DC ≥ PV the output stays high for the whole period. DC = 0 keeps the output low.
- R7: A write to the prescale, high-time or period value of a running channel takes effect only at the next period boundary.
- R8: Reads of unmapped or misaligned addresses (+0xC of windows 0 to 2, any address with bits [1:0] non-zero) return zero. Writes to those addresses change no register.
- R9: After a synchronous active-low reset, every register reads zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the counters |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 6 | Byte address for the read and the write |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 4 | One PWM output per channel, bit n for channel n |

## Verification
The embedded properties assume that bus_addr, bus_wr and bus_wdata are stable around each rising edge and that a write takes effect in a single cycle. The bench drives all bus inputs on the falling edge and never changes them near the rising edge. They also assume that shadow values change only while the channel is stopped or at a period boundary. The bench exercises this by rewriting a running channel in mid-period and by stopping and restarting channels at arbitrary phases. Prescale, period and high-time values are kept small, so that many full periods and boundaries fit into a short run.

// File: rtl/pwm_bank_pkg.sv
// Shared widths and types for the PWM bank.
// Assumes a 32-bit register bus and word-aligned byte addressing.
package pwm_bank_pkg;
    parameter int DATA_W  = 32;
    parameter int PSC_W   = 14;
    parameter int CNT_W   = 16;
    localparam int PSC_LSB = 2;

    // Register slot inside one 16-byte channel window.
    typedef enum logic [1:0] {
        SLOT_CTRL   = 2'd0,
        SLOT_DUTY   = 2'd1,
        SLOT_PERIOD = 2'd2,
        SLOT_SPARE  = 2'd3
    } slot_e;

    // Live settings of one channel.
    typedef struct packed {
        logic             en;
        logic [PSC_W-1:0] presc;
        logic [CNT_W-1:0] duty;
        logic [CNT_W-1:0] period;
    } chan_cfg_t;
endpackage

// File: rtl/pwm_bank_regs.sv
// Register file of the PWM bank: decodes the bus address, stores the per-channel
// settings and the global enable, and returns read data combinationally.
// Assumes ADDR_W = channel-select bits + 4 and that the global enable sits in the
// last word of the last window.
module pwm_bank_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wdata,
    output logic [DATA_W-1:0]        rdata,
    output chan_cfg_t [NUM_CH-1:0]   cfg_o,
    output logic                     master_o
);
    localparam int CH_W = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] MASTER_ADDR = ADDR_W'(NUM_CH * 16 - 4);

    chan_cfg_t [NUM_CH-1:0] cfg_q;
    logic                   master_q;
    logic [CH_W-1:0]        ch_sel;
    slot_e                  slot;
    logic                   aligned;
    logic                   is_master;
    logic                   chan_hit;

    // Split the address into channel, slot and alignment.
    always_comb begin
        ch_sel    = addr[ADDR_W-1:4];
        slot      = slot_e'(addr[3:2]);
        aligned   = (addr[1:0] == 2'b00);
        is_master = (addr == MASTER_ADDR);
        chan_hit  = aligned && !is_master && (slot != SLOT_SPARE)
                    && (int'(ch_sel) < NUM_CH);
    end

    // One write port per channel window.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan_reg
        // Store control, high-time and period words for channel g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && chan_hit && (ch_sel == CH_W'(g))) begin
                case (slot)
                    SLOT_CTRL: begin
                        cfg_q[g].en    <= wdata[0];
                        cfg_q[g].presc <= wdata[PSC_LSB +: PSC_W];
                    end
                    SLOT_DUTY:   cfg_q[g].duty   <= wdata[CNT_W-1:0];
                    SLOT_PERIOD: cfg_q[g].period <= wdata[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Store the global enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_q <= 1'b0;
        end else if (wr_en && is_master) begin
            master_q <= wdata[0];
        end
    end

    // Build read data; unmapped addresses give zero.
    always_comb begin
        rdata = '0;
        if (is_master) begin
            rdata[0] = master_q;
        end else if (chan_hit) begin
            case (slot)
                SLOT_CTRL: begin
                    rdata[0]                  = cfg_q[ch_sel].en;
                    rdata[PSC_LSB +: PSC_W]   = cfg_q[ch_sel].presc;
                end
                SLOT_DUTY:   rdata[CNT_W-1:0] = cfg_q[ch_sel].duty;
                SLOT_PERIOD: rdata[CNT_W-1:0] = cfg_q[ch_sel].period;
                default: ;
            endcase
        end
    end

    assign cfg_o    = cfg_q;
    assign master_o = master_q;

    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !chan_hit && !is_master) |=> ($stable(cfg_q) && $stable(master_q)));

    // R8
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_hit && !is_master) |-> (rdata == '0));

    // R2
    ctrl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_hit && slot == SLOT_CTRL) |->
        (rdata[1] == 1'b0 && rdata[DATA_W-1:PSC_LSB+PSC_W] == '0));

    // R3
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && is_master) |=> $stable(master_q));
endmodule

// File: rtl/pwm_bank_chan.sv
// One PWM channel: prescaler, period counter, shadow settings and output compare.
// Assumes run_i is registered upstream; the channel starts at period start one
// cycle after run_i rises and clears its counters one cycle after it falls.
module pwm_bank_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run_i,
    input  chan_cfg_t cfg_i,
    output logic      pwm_o
);
    logic             active_q;
    logic [PSC_W-1:0] psc_q;
    logic [CNT_W-1:0] per_q;
    logic [PSC_W-1:0] sh_presc;
    logic [CNT_W-1:0] sh_duty;
    logic [CNT_W-1:0] sh_period;
    logic [CNT_W:0]   per_nx;
    logic             tick;
    logic             last_per;
    logic             boundary;
    logic             reload;

    // Decide tick, end of period and shadow reload for this cycle.
    always_comb begin
        tick     = (psc_q == sh_presc);
        per_nx   = {1'b0, per_q} + (CNT_W+1)'(1);
        last_per = (per_nx >= {1'b0, sh_period});
        boundary = active_q && tick && last_per;
        reload   = !run_i || !active_q || boundary;
    end

    // Advance prescaler and period counters, or clear them while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            psc_q    <= '0;
            per_q    <= '0;
        end else if (!run_i || !active_q) begin
            active_q <= run_i;
            psc_q    <= '0;
            per_q    <= '0;
        end else if (tick) begin
            psc_q <= '0;
            per_q <= last_per ? '0 : per_q + CNT_W'(1);
        end else begin
            psc_q <= psc_q + PSC_W'(1);
        end
    end

    // Copy live settings into the shadow while stopped or at a period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_presc  <= '0;
            sh_duty   <= '0;
            sh_period <= '0;
        end else if (reload) begin
            sh_presc  <= cfg_i.presc;
            sh_duty   <= cfg_i.duty;
            sh_period <= cfg_i.period;
        end
    end

    assign pwm_o = active_q && (per_q < sh_duty);

    // R4
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !pwm_o);

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> (psc_q == '0 && per_q == '0));

    // R7
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && run_i && !boundary) |=>
        ($stable(sh_duty) && $stable(sh_period) && $stable(sh_presc)));

    // R5
    psc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (psc_q <= sh_presc));

    // R5
    per_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && sh_period != '0) |-> (per_q < sh_period));

    // R6
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && sh_duty != '0 && sh_duty >= sh_period) |-> pwm_o);
endmodule

// File: rtl/pwm_bank.sv
// Top of the four-channel PWM bank: register file plus one channel engine per
// output. A channel runs only while both the global and its own enable are set.
// Assumes a single clock domain and a bus that completes every write in one cycle.
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic                   master;

    pwm_bank_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr_en    (bus_wr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .cfg_o    (cfg),
        .master_o (master)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        logic run;
        // Gate the channel with the global enable.
        always_comb run = master && cfg[g].en;

        pwm_bank_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .run_i (run),
            .cfg_i (cfg[g]),
            .pwm_o (pwm_out[g])
        );
    end

    // R3
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master |=> (pwm_out == '0));
endmodule

// File: tb/pwm_bank_bench.sv
`timescale 1ns/1ps
module pwm_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R9";

    // Behavioural reference state.
    int     m_en[4], m_psc[4], m_duty[4], m_per[4];
    int     m_master;
    int     s_psc[4], s_duty[4], s_per[4];
    bit     act[4];
    longint elapsed[4];

    always #2 clk = ~clk;

    pwm_bank u_pwm_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [31:0] exp_read(logic [5:0] a);
        int ch;
        ch = int'(a[5:4]);
        if (a == 6'h3C) return {31'b0, m_master[0]};
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0: return {16'b0, m_psc[ch][13:0], 1'b0, m_en[ch][0]};
            2'd1: return {16'b0, m_duty[ch][15:0]};
            2'd2: return {16'b0, m_per[ch][15:0]};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(logic [5:0] a);
        if (a == 6'h3C) return "R3";
        if (a[1:0] != 2'b00 || a[3:2] == 2'd3) return "R8";
        return "R2";
    endfunction

    // Reference model: step on every edge, then compare outputs and read data.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_en[c] = 0; m_psc[c] = 0; m_duty[c] = 0; m_per[c] = 0;
                s_psc[c] = 0; s_duty[c] = 0; s_per[c] = 0;
                act[c] = 0; elapsed[c] = 0;
            end
            m_master = 0;
        end else begin
            for (int c = 0; c < 4; c++) begin
                bit run;
                longint len;
                run = (m_master != 0) && (m_en[c] != 0);
                if (!run || !act[c]) begin
                    act[c] = run; elapsed[c] = 0;
                    s_psc[c] = m_psc[c]; s_duty[c] = m_duty[c]; s_per[c] = m_per[c];
                end else begin
                    len = longint'(s_per[c] == 0 ? 1 : s_per[c]) * longint'(s_psc[c] + 1);
                    elapsed[c]++;
                    if (elapsed[c] == len) begin
                        elapsed[c] = 0;
                        s_psc[c] = m_psc[c]; s_duty[c] = m_duty[c]; s_per[c] = m_per[c];
                    end
                end
            end
            if (bus_wr) begin
                if (bus_addr == 6'h3C) m_master = int'(bus_wdata[0]);
                else if (bus_addr[1:0] == 2'b00) begin
                    int ch;
                    ch = int'(bus_addr[5:4]);
                    case (bus_addr[3:2])
                        2'd0: begin m_en[ch] = int'(bus_wdata[0]); m_psc[ch] = int'(bus_wdata[15:2]); end
                        2'd1: m_duty[ch] = int'(bus_wdata[15:0]);
                        2'd2: m_per[ch] = int'(bus_wdata[15:0]);
                        default: ;
                    endcase
                end
            end
        end
        #1;
        if (!done) begin
            for (int c = 0; c < 4; c++) begin
                bit e;
                e = act[c] && (elapsed[c] < longint'(s_duty[c]) * longint'(s_psc[c] + 1));
                checks++;
                if (pwm_out[c] !== e) begin
                    errors++;
                    $display("FAIL %s pwm_out[%0d] actual=%0b expected=%0b at %0t",
                             cur_req, c, pwm_out[c], e, $time);
                end
            end
            checks++;
            if (bus_rdata !== exp_read(bus_addr)) begin
                errors++;
                $display("FAIL %s read 0x%0h actual=0x%08h expected=0x%08h",
                         read_tag(bus_addr), bus_addr, bus_rdata, exp_read(bus_addr));
            end
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Directed read against a value taken from the requirement text.
    task automatic rd_chk(input logic [5:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #1;
        checks++;
        if (bus_rdata !== e) begin
            errors++;
            $display("FAIL %s directed read 0x%0h actual=0x%08h expected=0x%08h",
                     tag, a, bus_rdata, e);
        end
    endtask

    // Count high cycles of one output over n cycles and compare.
    task automatic high_chk(input int ch, input int n, input int e, input string tag);
        int h;
        h = 0;
        repeat (n) begin
            @(posedge clk);
            #1;
            h += int'(pwm_out[ch]);
        end
        checks++;
        if (h != e) begin
            errors++;
            $display("FAIL %s high count ch%0d actual=%0d expected=%0d", tag, ch, h, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R9: reset state.
        idle(4);
        rst_n = 1'b1;
        rd_chk(6'h00, 32'h0, "R9");
        rd_chk(6'h3C, 32'h0, "R9");
        high_chk(0, 4, 0, "R9");

        // R2: control packing, masked bits; R1: separate windows.
        cur_req = "R2";
        wr(6'h00, 32'hFFFF_FFFE);
        rd_chk(6'h00, 32'h0000_FFFC, "R2");
        wr(6'h14, 32'h1234_ABCD);
        rd_chk(6'h14, 32'h0000_ABCD, "R2");
        cur_req = "R1";
        for (int c = 0; c < 4; c++) wr(6'(c * 16 + 8), 32'(100 + c));
        for (int c = 0; c < 4; c++) rd_chk(6'(c * 16 + 8), 32'(100 + c), "R1");

        // R8: unmapped and misaligned accesses.
        cur_req = "R8";
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h2C, 32'hFFFF_FFFF);
        wr(6'h01, 32'hFFFF_FFFF);
        wr(6'h05, 32'hFFFF_FFFF);
        rd_chk(6'h0C, 32'h0, "R8");
        rd_chk(6'h01, 32'h0, "R8");
        rd_chk(6'h00, 32'h0000_FFFC, "R8");
        rd_chk(6'h04, 32'h0, "R8");
        rd_chk(6'h3C, 32'h0, "R8");

        // Channel setups: ch0 P0 DC2 PV5, ch1 P3 DC1 PV3, ch2 P1 DC9 PV4, ch3 P0 DC0 PV4.
        cur_req = "R3";
        wr(6'h04, 32'd2);  wr(6'h08, 32'd5);  wr(6'h00, 32'h1);
        wr(6'h14, 32'd1);  wr(6'h18, 32'd3);  wr(6'h10, 32'h0000_000D);
        wr(6'h24, 32'd9);  wr(6'h28, 32'd4);  wr(6'h20, 32'h0000_0005);
        wr(6'h34, 32'd0);  wr(6'h38, 32'd4);  wr(6'h30, 32'h1);
        high_chk(2, 20, 0, "R3");
        cur_req = "R4";
        wr(6'h3C, 32'h1);
        rd_chk(6'h3C, 32'h1, "R3");
        cur_req = "R5";
        high_chk(0, 50, 20, "R5");
        high_chk(1, 48, 16, "R5");
        cur_req = "R6";
        high_chk(2, 40, 40, "R6");
        high_chk(3, 40, 0, "R6");

        // R7: mid-period rewrite of running channels.
        cur_req = "R7";
        idle(3);
        wr(6'h14, 32'd2);
        wr(6'h18, 32'd6);
        idle(5);
        wr(6'h04, 32'd4);
        idle(60);
        high_chk(1, 48, 16, "R7");

        // R4: stop in mid-period, then restart from period start.
        cur_req = "R4";
        idle(2);
        wr(6'h00, 32'h0);
        high_chk(0, 10, 0, "R4");
        wr(6'h00, 32'h1);
        idle(30);

        // R5: period count zero behaves as one.
        cur_req = "R5";
        wr(6'h38, 32'd0);
        wr(6'h34, 32'd1);
        idle(20);
        high_chk(3, 12, 12, "R5");

        // R3: global enable off forces all low.
        cur_req = "R3";
        wr(6'h3C, 32'h0);
        idle(1);
        high_chk(2, 10, 0, "R3");

        idle(4);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule